// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block acts as a 256-byte non-volatile memory target on a two-wire serial bus. It works from a fast system clock. The bus lines come in as plain levels and are oversampled. The block answers only to its own device byte, which combines a fixed type code with the levels on three strap pins. It keeps an internal address pointer. It takes single bytes or bursts of up to one page of eight bytes, and it returns data from the pointer with auto-increment.

A write does not change the array at once. The bytes are staged in a small page buffer. They are committed only after a STOP, at the end of a self-timed write period of `WR_CYCLES` system clocks. During that period the block refuses every device byte. A bus master finds out when the write has finished by sending device bytes until one is acknowledged. A lock input blocks writes without disturbing the bus protocol. A repeated START before the STOP drops whatever was staged.

Top module: `twi_eeprom`

## Requirements
- R1: After reset `sda_oe` is 0, the write timer is idle, and every array byte reads as 0x00.
- R2: A device byte is acknowledged only when bits 7..4 are 4'b1010 and bits 3..1 equal `chip_sel`. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. Any other device byte is not acknowledged, and the block stays off the bus until the next START.
- R3: The block pulls SDA low (`sda_oe` = 1) only during the ninth clock of an accepted byte, or while it sends a 0 data bit. It changes `sda_oe` only while SCL is low, except that a START or STOP releases it.
- R4: In a write, the byte that follows the device byte is loaded as the 8-bit address pointer and is acknowledged.
- R5: Each data byte of a write is acknowledged. After STOP and the write period, the byte is found at the pointer value it was received at.
- R6: Each accepted write data byte advances only pointer bits 2..0, modulo 8. Bits 7..3 stay fixed. A burst of any length from 1 upward is accepted, and a later byte at the same slot replaces an earlier one.
- R7: A STOP that ends a write with at least one staged byte starts a write period of `WR_CYCLES` clocks. During that period no device byte is acknowledged. The staged bytes reach the array when the period ends.
- R8: While `wr_lock` is 1, write data bytes are still acknowledged but are dropped. If a write has no bytes staged, its STOP starts no write period, so a device byte sent right after it is acknowledged.
- R9: A START that arrives before the STOP of a write discards all staged bytes, and no write period follows.
- R10: A read returns the byte at the pointer, MSB first, and moves the pointer up by one per byte across the full range, wrapping from 0xFF to 0x00. After a write the pointer is at the next in-page slot.
- R11: After the master answers a read byte with NACK (SDA high in the ninth clock), the block stops driving SDA until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| chip_sel | input | 3 | Hard-wired strap levels compared with device byte bits 3..1 |
| wr_lock | input | 1 | 1 blocks every array update |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
Several rules are checked on every cycle by assertions. The block drives SDA outside the ninth clock only when it is sending read data. It releases the line in the master's acknowledge slot. Its output enable never moves while SCL is high, apart from a START or STOP. No write period is requested while one is already running, and no byte is staged during one. Other behaviour can only be shown by bench scenarios, because it depends on a whole transaction: page wrap and overwrite, commit only after the timed period, the polled NACK, lock and repeated-START discarding, and the pointer moving across the 0xFF boundary.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_DACK_RD,
    S_WADDR,
    S_WDATA,
    S_READ,
    S_SKIP
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Device byte selects this target: type code and strap match.
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] cs);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == cs);
  endfunction

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_p[1];
  assign sda_lvl  = sda_p[1];
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign start_ev = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_ev  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/twi_store.sv
module twi_store #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 5000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     stage_we,
  input  logic [PAGE_W-1:0]        stage_idx,
  input  logic [7:0]               stage_data,
  input  logic [ADDR_W-PAGE_W-1:0] stage_row,
  input  logic                     stage_clr,
  input  logic                     commit_req,
  output logic                     busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  mask;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt;
  logic             commit_now;

  assign rd_data    = mem[rd_addr];
  assign commit_now = busy && (cnt == CNT_W'(WR_CYCLES - 1));

  // Staging buffer and write timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      row_q <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (commit_now) begin
        busy <= 1'b0;
        mask <= '0;
      end
    end else if (stage_clr) begin
      mask <= '0;
    end else if (commit_req && (|mask)) begin
      busy  <= 1'b1;
      cnt   <= '0;
      row_q <= stage_row;
    end else if (stage_we) begin
      pbuf[stage_idx] <= stage_data;
      mask[stage_idx] <= 1'b1;
    end
  end

  // Array: staged slots land together at the end of the timed period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      for (int i = 0; i < PAGE; i++)
        if (commit_now && mask[i]) mem[{row_q, PAGE_W'(i)}] <= pbuf[i];
    end
  end

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> !busy);

  // R7
  no_stage_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we |-> !busy);
endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  input  logic       wr_lock,
  output logic       sda_oe
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  twi_eeprom_pkg::twi_state_e state;
  logic [3:0]        bit_cnt;
  logic [7:0]        sh;
  logic [ADDR_W-1:0] addr;
  logic              mack;
  logic [7:0]        rd_data;
  logic              busy;
  logic              byte_done, dev_ok, stage_we, commit_req;
  logic [3:0]        tx_idx;

  // Pointer step within the page: low bits wrap, row kept.
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  twi_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_done  = scl_fall && (bit_cnt == 4'd8) && !start_ev && !stop_ev;
  assign dev_ok     = dev_hit(sh, chip_sel) && !busy;
  assign stage_we   = byte_done && (state == S_WDATA) && !wr_lock;
  assign commit_req = stop_ev && (state == S_WDATA);
  assign tx_idx     = 4'd7 - bit_cnt;

  twi_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
    .stage_we(stage_we), .stage_idx(addr[PAGE_W-1:0]), .stage_data(sh),
    .stage_row(addr[ADDR_W-1:PAGE_W]), .stage_clr(start_ev),
    .commit_req(commit_req), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
      sh      <= '0;
      addr    <= '0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state   <= S_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            sh      <= {sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= 4'd9;
            if (state == S_DEV) begin
              if (dev_ok) begin
                sda_oe <= 1'b1;
                state  <= sh[0] ? S_DACK_RD : S_WADDR;
              end else begin
                state  <= S_SKIP;
              end
            end else if (state == S_WADDR) begin
              addr   <= ADDR_W'(sh);
              sda_oe <= 1'b1;
              state  <= S_WDATA;
            end else begin
              addr   <= page_step(addr);
              sda_oe <= 1'b1;
            end
          end else if (scl_fall && bit_cnt == 4'd9) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
          end
        end
        S_DACK_RD: begin
          if (scl_fall) begin
            state   <= S_READ;
            bit_cnt <= '0;
            sda_oe  <= ~rd_data[7];
          end
        end
        S_READ: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_rise && bit_cnt == 4'd9) begin
            mack <= ~sda_lvl;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            sda_oe  <= 1'b0;
            bit_cnt <= 4'd9;
            addr    <= addr + 1'b1;
          end else if (scl_fall && bit_cnt == 4'd9) begin
            if (mack) begin
              bit_cnt <= '0;
              sda_oe  <= ~rd_data[7];
            end else begin
              state   <= S_IDLE;
            end
          end else if (scl_fall && bit_cnt != 4'd0) begin
            sda_oe <= ~rd_data[tx_idx[2:0]];
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && state != S_READ) |-> bit_cnt == 4'd9);

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_ev || stop_ev)) |-> !$past(scl_lvl));

  // R11
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && bit_cnt == 4'd9) |-> !sda_oe);

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_DEV && busy) |=> !sda_oe);
endmodule

// File: tb/twi_eeprom_bench.sv
`timescale 1ns/1ps
module twi_eeprom_bench;
  localparam int H   = 4;
  localparam int WRC = 800;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_lock = 1'b0;
  logic sda_oe, sda_line;
  int checks = 0, errors = 0;
  logic [7:0] mem_m [256];
  logic [7:0] ptr_m;
  logic [7:0] wbuf [16];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom #(.ADDR_W(8), .PAGE_W(3), .WR_CYCLES(WRC)) u_twi_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .chip_sel(CS), .wr_lock(wr_lock), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] page_addr(input logic [7:0] a, input int k);
    logic [2:0] lo;
    lo = a[2:0] + 3'(k);
    return {a[7:3], lo};
  endfunction

  function automatic logic [7:0] devb(input logic [2:0] cs, input logic rd);
    return {4'b1010, cs, rd};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    hw(); sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0;
  endtask

  task automatic bstop();
    hw(); sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      hw(); sda_m = b[i]; hw(); scl_m = 1'b1; hw(); hw(); scl_m = 1'b0;
    end
    hw(); sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
    ack = (sda_line == 1'b0);
    hw(); scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); hw(); scl_m = 1'b1; hw(); d[i] = sda_line; hw(); scl_m = 1'b0;
    end
    hw(); sda_m = ~give_ack; hw(); scl_m = 1'b1; hw(); hw(); scl_m = 1'b0;
    hw(); sda_m = 1'b1;
  endtask

  task automatic write_burst(input logic [7:0] a, input int n, input logic locked);
    logic ack;
    bstart();
    wbyte(devb(CS, 1'b0), ack); chk(ack, "R2 dev write ack", ack, 1);
    wbyte(a, ack);              chk(ack, "R4 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], ack);
      chk(ack, locked ? "R8 data ack under lock" : "R5 data ack", ack, 1);
      if (!locked) mem_m[page_addr(a, k)] = wbuf[k];
    end
    bstop();
    ptr_m = page_addr(a, n);
  endtask

  task automatic wait_done();
    logic ack;
    int polls;
    polls = 0;
    ack = 1'b0;
    while (!ack && polls < 40) begin
      bstart(); wbyte(devb(CS, 1'b0), ack); bstop();
      polls++;
    end
    chk(ack, "R7 write period ends", ack, 1);
    chk(polls > 1, "R7 first poll refused", polls, 2);
  endtask

  task automatic read_tail(input logic [7:0] a, input int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, d);
      chk(d == mem_m[8'(a + k)], "R10 read data", d, mem_m[8'(a + k)]);
    end
    chk(sda_oe == 1'b0, "R11 released after NACK", sda_oe, 0);
    hw();
    chk(sda_oe == 1'b0, "R11 still released", sda_oe, 0);
    bstop();
    ptr_m = 8'(a + n);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n);
    logic ack;
    bstart();
    wbyte(devb(CS, 1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
    wbyte(a, ack);              chk(ack, "R4 address ack", ack, 1);
    bstart();
    wbyte(devb(CS, 1'b1), ack); chk(ack, "R2 dev read ack", ack, 1);
    read_tail(a, n);
  endtask

  task automatic cur_read(input int n);
    logic ack;
    bstart();
    wbyte(devb(CS, 1'b1), ack); chk(ack, "R10 current read ack", ack, 1);
    read_tail(ptr_m, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'h5eed1234));
    for (int a = 0; a < 256; a++) mem_m[a] = 8'h00;
    ptr_m = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    hw();
    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    rand_read(8'h00, 3);

    // R2: wrong straps, wrong type code
    bstart(); wbyte(devb(3'b011, 1'b0), ack); bstop();
    chk(!ack, "R2 strap mismatch nack", ack, 0);
    bstart(); wbyte(8'b1011_1010, ack); bstop();
    chk(!ack, "R2 type mismatch nack", ack, 0);
    chk(sda_oe == 1'b0, "R2 off bus after nack", sda_oe, 0);

    // R5 R7: single byte write with polling
    wbuf[0] = 8'hA5;
    write_burst(8'h10, 1, 1'b0);
    bstart(); wbyte(devb(CS, 1'b0), ack); bstop();
    chk(!ack, "R7 busy refuses device byte", ack, 0);
    wait_done();
    rand_read(8'h10, 1);

    // R6: wrap inside the page, then overwrite with 10 bytes
    for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'h30 + k);
    write_burst(8'h1E, 5, 1'b0);
    wait_done();
    rand_read(8'h18, 8);
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'h80 + k);
    write_burst(8'h40, 10, 1'b0);
    wait_done();
    // R10: pointer sits at next in-page slot after a write
    cur_read(2);
    rand_read(8'h40, 8);

    // R10: wrap 0xFF -> 0x00
    for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
    write_burst(8'hF8, 8, 1'b0);
    wait_done();
    wbuf[0] = 8'h5C;
    write_burst(8'h00, 1, 1'b0);
    wait_done();
    rand_read(8'hFD, 5);
    cur_read(1);

    // R8: lock drops data, no write period
    wr_lock = 1'b1;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'hE0 + k);
    write_burst(8'h60, 3, 1'b1);
    bstart(); wbyte(devb(CS, 1'b0), ack); bstop();
    chk(ack, "R8 no write period under lock", ack, 1);
    wr_lock = 1'b0;
    rand_read(8'h60, 3);

    // R9: repeated START discards staged bytes
    bstart();
    wbyte(devb(CS, 1'b0), ack);
    wbyte(8'h70, ack);
    wbyte(8'hDE, ack);
    wbyte(8'hAD, ack);
    bstart();
    wbyte(devb(CS, 1'b1), ack);
    chk(ack, "R9 read after repeated START", ack, 1);
    read_tail(8'h72, 1);
    bstart(); wbyte(devb(CS, 1'b0), ack); bstop();
    chk(ack, "R9 no write period", ack, 1);
    rand_read(8'h70, 2);

    // Random bursts and reads
    for (int it = 0; it < 10; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      n = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_burst(a, n, 1'b0);
      wait_done();
      rand_read({a[7:3], 3'b000}, 8);
      if (it % 3 == 0) cur_read(1 + int'($urandom % 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule